// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync-Error Retransmit

This block shifts data elements out on a single serial line, most significant bit first, with one bit per rising edge of the bit clock `clk_i`. A writer places a word in a one-entry holding register. A frame sync pulse then starts the element after a programmable data delay of 0, 1 or 2 bit clocks. The holding register stays occupied until the element has been sent through to its last bit, so that element can be sent again if a transfer is interrupted.

Some frame sync pulses arrive too early. These are pulses that come more than the data delay before the end of the element in progress, or while the data delay is still running. A configuration bit selects how such pulses are treated. With the bit cleared, an early pulse aborts the shift and sets a sticky sync-error flag. The same element is then sent again from its first bit, starting the data delay after the aborting pulse. With the bit set, early pulses are disregarded and the element finishes undisturbed.

Top module: `frame_tx`

## Requirements
- R1: `cfg_len_i` selects the element length: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Bits `len-1` down to 0 of the written word are sent, most significant first.
- R2: A frame sync sampled at rising edge k, while the block is idle and the holding register is full, puts bit i of the element on `dout_o` from edge k+d+i. Here d is `cfg_dly_i`, and the value 3 acts as 2.
- R3: A frame sync that arrives while the holding register is empty starts nothing. `dout_o` stays low and `wr_ready_o` stays high.
- R4: With `cfg_fig_i` low, a frame sync is unexpected in two cases: it is sampled during the data delay, or it is sampled at an edge more than d edges before the edge that ends the element (edge k+d+len). An unexpected sync aborts the element in progress.
- R5: After an abort, the interrupted element is sent again in full, starting from its first bit, with bit 0 appearing d edges after the aborting sync edge.
- R6: An abort sets `serr_o`. It stays set until a `serr_clr_i` pulse clears it.
- R7: With `cfg_fig_i` high, an unexpected frame sync changes neither the bits on `dout_o` nor `serr_o`.
- R8: A frame sync sampled within the last d edges before the end of an element is neither an error nor a start. The element completes unchanged.
- R9: `wr_ready_o` is high exactly when the holding register is empty. A write with `wr_valid_i` high and `wr_ready_o` high is taken. The register stays full through aborts and is released at the edge that ends an element sent without abort. Writes made while it is full are ignored.
- R10: `dout_o` is low whenever no element bit is being driven: while idle and during a data delay, including the delay after an abort.
- R11: After reset, `dout_o` is low, `wr_ready_o` is high and `serr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync pulse |
| cfg_fig_i | input | 1 | 1: ignore unexpected frame syncs |
| cfg_dly_i | input | 2 | Data delay in bit clocks (0..2) |
| cfg_len_i | input | 2 | Element length select |
| wr_valid_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Word to transmit |
| wr_ready_o | output | 1 | Holding register empty |
| serr_clr_i | input | 1 | Clears the sync-error flag |
| serr_o | output | 1 | Sticky transmit sync-error flag |
| dout_o | output | 1 | Serial data out |

## Verification
Bit i of an element is due on `dout_o` after rising edge k+d+i, where k is the edge that samples the frame sync. `dout_o` returns low and `wr_ready_o` returns high after edge k+d+len. `serr_o` shows an abort after the edge that samples the offending pulse. The bench drives every input on falling edges and samples one falling edge after the edge at which each result is due. It raises mid-element syncs so that they are sampled at the edge that drives a chosen bit. This lets the boundary between an abort (bit len-d-1) and an ignored pulse (bit len-d) be hit exactly. Retransmitted bits are counted from the aborting edge, not from the original sync.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SHIFT} tx_state_e;

  function automatic int unsigned elem_len(input logic [1:0] sel, input int unsigned dw);
    case (sel)
      2'd0:    return dw / 4;
      2'd1:    return dw / 2;
      default: return dw;
    endcase
  endfunction

  function automatic logic [1:0] eff_dly(input logic [1:0] d);
    return (d == 2'd3) ? 2'd2 : d;
  endfunction
endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              release_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (release_i) begin
      full_q <= 1'b0;
    end else if (wr_valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/frame_tx_timing.sv
module frame_tx_timing
  import frame_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W),
  localparam int unsigned LEN_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  input  logic             fig_i,
  input  logic [1:0]       dly_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             hold_full_i,
  output logic             start_o,
  output logic             shift_o,
  output logic             clear_o,
  output logic             done_o,
  output logic             abort_o
);
  tx_state_e        st_q, st_d;
  logic [1:0]       dcnt_q, dcnt_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] dly_ext, len_m1;
  logic             unexp, launch, start, clear;

  assign dly_ext = {{(CNT_W-2){1'b0}}, dly_i};
  assign len_m1  = CNT_W'(len_i - LEN_W'(1));

  // early sync: still in delay, or end of element lies more than d edges away
  assign unexp   = fs_i && ((st_q == ST_DELAY) || (st_q == ST_SHIFT && rem_q > dly_ext));
  assign abort_o = unexp && !fig_i;

  always_comb begin
    st_d    = st_q;
    dcnt_d  = dcnt_q;
    rem_d   = rem_q;
    launch  = 1'b0;
    start   = 1'b0;
    shift_o = 1'b0;
    clear   = 1'b0;
    done_o  = 1'b0;
    case (st_q)
      ST_IDLE:  if (fs_i && hold_full_i) launch = 1'b1;
      ST_DELAY: begin
        if (abort_o)              launch = 1'b1;
        else if (dcnt_q == 2'd0)  start  = 1'b1;
        else                      dcnt_d = dcnt_q - 2'd1;
      end
      ST_SHIFT: begin
        if (abort_o) launch = 1'b1;
        else if (rem_q == '0) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          shift_o = 1'b1;
          rem_d   = rem_q - CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (launch) begin
      if (dly_i == 2'd0) start = 1'b1;
      else begin
        st_d   = ST_DELAY;
        dcnt_d = dly_i - 2'd1;
        clear  = 1'b1;
      end
    end
    if (start) begin
      st_d  = ST_SHIFT;
      rem_d = len_m1;
    end
  end

  assign start_o = start;
  assign clear_o = clear | done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      rem_q  <= rem_d;
    end
  end
endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic              dout_o
);
  logic [DATA_W-1:0] sr_q, aligned;
  logic [LEN_W-1:0]  shamt;
  logic              dout_q;

  // left-justify the element so its MSB sits at the top of the register
  assign shamt   = LEN_W'(DATA_W) - len_i;
  assign aligned = hold_i << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
    end else if (start_i) begin
      dout_q <= aligned[DATA_W-1];
      sr_q   <= aligned << 1;
    end else if (clear_i) begin
      dout_q <= 1'b0;
    end else if (shift_i) begin
      dout_q <= sr_q[DATA_W-1];
      sr_q   <= sr_q << 1;
    end
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/frame_tx_serr.sv
module frame_tx_serr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              cfg_fig_i,
  input  logic [1:0]        cfg_dly_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              serr_clr_i,
  output logic              serr_o,
  output logic              dout_o
);
  localparam int unsigned LEN_W = $clog2(DATA_W) + 1;

  logic              hold_full, start, shift, clear, done, abort;
  logic [DATA_W-1:0] hold_data;
  logic [LEN_W-1:0]  len_w;
  logic [1:0]        dly_w;

  assign len_w      = LEN_W'(elem_len(cfg_len_i, DATA_W));
  assign dly_w      = eff_dly(cfg_dly_i);
  assign wr_ready_o = !hold_full;

  frame_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni,
    .wr_valid_i, .wr_data_i,
    .release_i (done),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  frame_tx_timing #(.DATA_W(DATA_W)) u_timing (
    .clk_i, .rst_ni, .fs_i,
    .fig_i       (cfg_fig_i),
    .dly_i       (dly_w),
    .len_i       (len_w),
    .hold_full_i (hold_full),
    .start_o     (start),
    .shift_o     (shift),
    .clear_o     (clear),
    .done_o      (done),
    .abort_o     (abort)
  );

  frame_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .hold_i  (hold_data),
    .len_i   (len_w),
    .start_i (start),
    .shift_i (shift),
    .clear_i (clear),
    .dout_o
  );

  frame_tx_serr u_serr (
    .clk_i, .rst_ni,
    .set_i  (abort),
    .clr_i  (serr_clr_i),
    .flag_o (serr_o)
  );
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fs_i,
  input logic cfg_fig_i,
  input logic serr_clr_i,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic serr_o,
  input logic dout_o
);
  // R10
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> !dout_o);

  // R6
  serr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o && !serr_clr_i |=> serr_o);

  // R6
  serr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_clr_i && !fs_i |=> !serr_o);

  // R4
  serr_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_o ##1 serr_o |-> $past(fs_i));

  // R7
  fig_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_fig_i && !serr_o |=> !serr_o);

  // R9
  ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o ##1 !wr_ready_o |-> $past(wr_valid_i));
endmodule

bind frame_tx frame_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fs_i       (fs_i),
  .cfg_fig_i  (cfg_fig_i),
  .serr_clr_i (serr_clr_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .serr_o     (serr_o),
  .dout_o     (dout_o)
);

// File: tb/frame_tx_bench.sv
module frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fs_i = 1'b0;
  logic              cfg_fig_i = 1'b0;
  logic [1:0]        cfg_dly_i = 2'd0;
  logic [1:0]        cfg_len_i = 2'd0;
  logic              wr_valid_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              serr_clr_i = 1'b0;
  logic              wr_ready_o, serr_o, dout_o;

  int n_chk  = 0;
  int n_fail = 0;

  frame_tx #(.DATA_W(DATA_W)) u_frame_tx (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input logic [1:0] sel);
    return (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
  endfunction

  task automatic write_word(input logic [31:0] data);
    check("R9 ready before write", 32'(wr_ready_o), 1);
    wr_valid_i = 1'b1;
    wr_data_i  = data;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    check("R9 ready after write", 32'(wr_ready_o), 0);
  endtask

  task automatic fire_fs();
    fs_i = 1'b1;
    @(negedge clk_i);
    fs_i = 1'b0;
  endtask

  // checks delay slots then bits 0..upto-1; raises a sync seen at the edge driving bit fs_at
  task automatic expect_bits(input int d, input int len, input logic [31:0] data,
                             input int fs_at, input int upto, input string req);
    for (int k = 0; k < d; k++) begin
      check({req, " R10 delay low"}, 32'(dout_o), 0);
      @(negedge clk_i);
    end
    for (int i = 0; i < upto; i++) begin
      check(req, 32'(dout_o), 32'(data[len-1-i]));
      if (i + 1 == fs_at) begin
        fs_i       = 1'b1;
        wr_valid_i = 1'b1;
        wr_data_i  = ~data;
      end
      @(negedge clk_i);
      fs_i       = 1'b0;
      wr_valid_i = 1'b0;
    end
  endtask

  task automatic end_checks(input string req);
    check({req, " R10 low after end"}, 32'(dout_o), 0);
    check({req, " R9 released"}, 32'(wr_ready_o), 1);
  endtask

  task automatic t_reset();
    check("R11 dout", 32'(dout_o), 0);
    check("R11 ready", 32'(wr_ready_o), 1);
    check("R11 serr", 32'(serr_o), 0);
  endtask

  task automatic t_basic(input logic [1:0] sel, input logic [1:0] d, input logic [31:0] data);
    int dd = (d == 2'd3) ? 2 : int'(d);
    cfg_len_i = sel; cfg_dly_i = d; cfg_fig_i = 1'b0;
    write_word(data);
    fire_fs();
    expect_bits(dd, len_of(sel), data, -1, len_of(sel), "R1 R2 bits");
    end_checks("R2");
  endtask

  task automatic t_empty_fs();
    fire_fs();
    for (int k = 0; k < 3; k++) begin
      check("R3 empty sync dout", 32'(dout_o), 0);
      check("R3 empty sync ready", 32'(wr_ready_o), 1);
      @(negedge clk_i);
    end
  endtask

  task automatic t_abort(input logic [1:0] sel, input int d, input logic [31:0] data, input int j);
    cfg_len_i = sel; cfg_dly_i = 2'(d); cfg_fig_i = 1'b0;
    write_word(data);
    fire_fs();
    expect_bits(d, len_of(sel), data, j, j, "R4 pre-abort");
    check("R6 serr set", 32'(serr_o), 1);
    check("R9 held on abort", 32'(wr_ready_o), 0);
    expect_bits(d, len_of(sel), data, -1, len_of(sel), "R5 resend");
    end_checks("R5");
  endtask

  task automatic t_ignore(input logic [1:0] sel, input int d, input logic [31:0] data, input int j);
    cfg_len_i = sel; cfg_dly_i = 2'(d); cfg_fig_i = 1'b1;
    write_word(data);
    fire_fs();
    expect_bits(d, len_of(sel), data, j, len_of(sel), "R7 ignored");
    check("R7 serr", 32'(serr_o), 0);
    end_checks("R7");
    cfg_fig_i = 1'b0;
  endtask

  task automatic t_window(input logic [31:0] data);
    cfg_len_i = 2'd0; cfg_dly_i = 2'd2; cfg_fig_i = 1'b0;
    write_word(data);
    fire_fs();
    expect_bits(2, 8, data, 6, 8, "R8 window");
    check("R8 serr", 32'(serr_o), 0);
    end_checks("R8");
    for (int k = 0; k < 3; k++) begin
      check("R8 no start", 32'(dout_o), 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_clear();
    repeat (3) @(negedge clk_i);
    check("R6 sticky", 32'(serr_o), 1);
    serr_clr_i = 1'b1;
    @(negedge clk_i);
    serr_clr_i = 1'b0;
    check("R6 cleared", 32'(serr_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic(2'd0, 2'd0, 32'h0000_00B5);
    t_basic(2'd1, 2'd1, 32'h0000_C3A1);
    t_basic(2'd2, 2'd2, 32'h8F01_7E5C);
    t_basic(2'd3, 2'd3, 32'h5A5A_0FF1);
    t_empty_fs();
    t_abort(2'd1, 1, 32'h0000_9D27, 5);
    t_clear();
    t_abort(2'd2, 0, 32'hA1B2_C3D4, 10);
    t_clear();
    t_abort(2'd0, 2, 32'h0000_006B, 5);
    t_clear();
    t_ignore(2'd1, 1, 32'h0000_E44C, 4);
    t_window(32'h0000_00D3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule